// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects five interrupt sources (two external lines, two timer overflow events and one serial event) and decides which of them the processor core should service next. Each source passes a global enable and its own enable bit. The block then resolves the surviving requests first by a per-source two-level priority selection and then by a fixed order within each level. The result is a single request line towards the core's sequencer.

The core raises `instr_boundary` in the cycle in which it could branch to a handler. If a request is then eligible, the block grants it on that edge. One cycle later it pulses `irq_ack` and drives the handler's vector address, which stays on `irq_vec` until the next grant. The block records which priority levels are in service. A high-level handler therefore cannot be interrupted, and a low-level handler can be interrupted only by a high-level request. A `reti` pulse from the core ends the innermost active level. Stack handling and program counter loading stay in the core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `irq_req`, `irq_ack` and `irq_vec` are all zero and neither priority level is in service.
- R2: An external source whose mode bit is 0 (level mode) is pending while its active-low line is low. `irq_req` follows a change of the line one clock later, and releasing the line withdraws the request.
- R3: An external source whose mode bit is 1 (edge mode) latches a flag on a high-to-low transition of its line. The flag remains after the line returns high, and it is cleared only when that source is granted.
- R4: A one-cycle timer overflow pulse latches a flag that is cleared when that timer is granted. The serial request follows its input and is not cleared by a grant.
- R5: Source index order is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, and bit i of `irq_en` and `irq_prio` belongs to source i. A source can raise `irq_req` only when its `irq_en` bit and `glb_en` are both 1.
- R6: Any enabled pending source whose `irq_prio` bit is 1 wins over every source whose bit is 0. Within one level, the lowest source index wins.
- R7: The vector for source i is VEC_BASE + i*VEC_STRIDE. With the defaults these are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R8: A grant happens on a rising edge where `instr_boundary` and `irq_req` are 1 and `reti` is 0. `irq_ack` is 1 in the following cycle with the winner's vector on `irq_vec`, and `irq_vec` changes at no other time.
- R9: While the low level is in service, only a high-priority source can raise `irq_req`. While the high level is in service, no source can.
- R10: A `reti` pulse clears the high in-service level if it is set, and otherwise clears the low level. A grant is suppressed in a cycle where `reti` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_n | input | 2 | External request lines, active low (index 0 and 1) |
| ext_edge | input | 2 | Per external line: 1 = falling-edge latched, 0 = level |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow pulses |
| ser_irq | input | 1 | Serial port request level |
| glb_en | input | 1 | Global interrupt enable |
| irq_en | input | 5 | Per-source enable, bit i = source i |
| irq_prio | input | 5 | Per-source level, 1 = high |
| instr_boundary | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | An eligible request exists |
| irq_ack | output | 1 | One-cycle grant acknowledge |
| irq_vec | output | ADDR_W | Vector of the last granted source |

## Verification
Source flags are registered, so `irq_req` reacts one rising edge after an input or a `reti` changes. The priority and enable inputs act combinationally on the registered flags, so they affect `irq_req` in the same cycle. `irq_ack` and the new `irq_vec` appear one edge after the boundary edge that grants, and the flag clear and the in-service update take effect on that same edge. The bench changes inputs on falling edges and reads outputs at the next falling edge. Each check therefore sits exactly one rising edge after its stimulus, or one edge after the grant or `reti` it depends on.

// File: rtl/irq_pkg.sv
package irq_pkg;

   localparam int unsigned NUM_SRC = 5;
   localparam int unsigned NUM_EXT = 2;
   localparam int unsigned NUM_TMR = 2;
   localparam int unsigned IDX_W   = $clog2(NUM_SRC);

   typedef enum logic [1:0] {
      KIND_EXT,
      KIND_TMR,
      KIND_SER
   } src_kind_e;

   typedef struct packed {
      logic             valid;
      logic             hi;
      logic [IDX_W-1:0] idx;
   } pick_t;

   // Sources alternate external/timer, serial last.
   function automatic src_kind_e kind_of(input int unsigned s);
      if (s == NUM_SRC - 1) return KIND_SER;
      if (s % 2 == 0)       return KIND_EXT;
      return KIND_TMR;
   endfunction

   // Slot inside the external or timer group.
   function automatic int unsigned slot_of(input int unsigned s);
      return s / 2;
   endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
   import irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_n,
   input  logic [NUM_EXT-1:0] ext_edge,
   input  logic [NUM_TMR-1:0] tmr_ovf,
   input  logic               ser_irq,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] flags
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (kind_of(s) == KIND_EXT) begin : g_ext
         localparam int unsigned SL = slot_of(s);
         logic line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_q   <= 1'b1;
               flags[s] <= 1'b0;
            end else begin
               line_q <= ext_n[SL];
               if (ext_edge[SL]) begin
                  if (line_q && !ext_n[SL])
                     flags[s] <= 1'b1;
                  else if (clr[s])
                     flags[s] <= 1'b0;
               end else begin
                  flags[s] <= !ext_n[SL];
               end
            end
         end
      end else if (kind_of(s) == KIND_TMR) begin : g_tmr
         localparam int unsigned SL = slot_of(s);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flags[s] <= 1'b0;
            else if (tmr_ovf[SL])
               flags[s] <= 1'b1;
            else if (clr[s])
               flags[s] <= 1'b0;
         end
      end else begin : g_ser
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flags[s] <= 1'b0;
            else
               flags[s] <= ser_irq;
         end
      end
   end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_pkg::*;
(
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] prio_hi,
   output pick_t              pick
);

   localparam int unsigned LEVELS = 2;

   pick_t lvl_pick [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic [NUM_SRC-1:0] cand;
      assign cand = (l == 1) ? (pend & prio_hi) : (pend & ~prio_hi);

      always_comb begin
         lvl_pick[l] = '0;
         lvl_pick[l].hi = (l == 1);
         for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (cand[k]) begin
               lvl_pick[l].valid = 1'b1;
               lvl_pick[l].idx   = IDX_W'(k);
            end
         end
      end
   end

   assign pick = lvl_pick[1].valid ? lvl_pick[1] : lvl_pick[0];

endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic fire_hi,
   input  logic reti,
   output logic svc_hi,
   output logic svc_lo
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_hi <= 1'b0;
         svc_lo <= 1'b0;
      end else if (reti) begin
         if (svc_hi) svc_hi <= 1'b0;
         else        svc_lo <= 1'b0;
      end else if (fire) begin
         if (fire_hi) svc_hi <= 1'b1;
         else         svc_lo <= 1'b1;
      end
   end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_n,
   input  logic [NUM_EXT-1:0] ext_edge,
   input  logic [NUM_TMR-1:0] tmr_ovf,
   input  logic               ser_irq,
   input  logic               glb_en,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic [NUM_SRC-1:0] irq_prio,
   input  logic               instr_boundary,
   input  logic               reti,
   output logic               irq_req,
   output logic               irq_ack,
   output logic [ADDR_W-1:0]  irq_vec
);

   localparam longint unsigned VEC_TOP = longint'(VEC_BASE) + longint'(NUM_SRC - 1) * VEC_STRIDE;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (VEC_STRIDE > 0) else $error("VEC_STRIDE must be nonzero");
      assert (VEC_TOP < (64'd1 << ADDR_W)) else $error("vectors do not fit ADDR_W");
   end

   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] clr;
   pick_t              pick;
   logic               svc_hi;
   logic               svc_lo;
   logic               fire;
   logic [ADDR_W-1:0]  vec_next;

   irq_flag_bank u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_n    (ext_n),
      .ext_edge (ext_edge),
      .tmr_ovf  (tmr_ovf),
      .ser_irq  (ser_irq),
      .clr      (clr),
      .flags    (flags)
   );

   assign pend = flags & irq_en & {NUM_SRC{glb_en}};

   irq_prio_resolver u_res (
      .pend    (pend),
      .prio_hi (irq_prio),
      .pick    (pick)
   );

   assign irq_req = pick.valid && !svc_hi && (pick.hi || !svc_lo);
   assign fire    = instr_boundary && irq_req && !reti;

   irq_svc_tracker u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .fire_hi (pick.hi),
      .reti    (reti),
      .svc_hi  (svc_hi),
      .svc_lo  (svc_lo)
   );

   always_comb begin
      clr = '0;
      if (fire) clr[pick.idx] = 1'b1;
   end

   assign vec_next = ADDR_W'(VEC_BASE) + ADDR_W'(pick.idx) * ADDR_W'(VEC_STRIDE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_ack <= 1'b0;
         irq_vec <= '0;
      end else begin
         irq_ack <= fire;
         if (fire) irq_vec <= vec_next;
      end
   end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              glb_en,
   input logic              instr_boundary,
   input logic              reti,
   input logic              irq_req,
   input logic              irq_ack,
   input logic [ADDR_W-1:0] irq_vec,
   input logic              svc_hi,
   input logic              svc_lo
);

   p_ack_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> ($past(instr_boundary) && $past(irq_req) && !$past(reti)));

   p_grant_acked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_boundary && irq_req && !reti) |=> irq_ack);

   p_vec_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_ack |-> $stable(irq_vec));

   p_global_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !irq_req);

   p_hi_blocks_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      svc_hi |-> !irq_req);

   p_reti_ends_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && svc_hi) |=> (!svc_hi && $stable(svc_lo)));

   p_reti_ends_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !svc_hi) |=> !svc_lo);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .glb_en         (glb_en),
   .instr_boundary (instr_boundary),
   .reti           (reti),
   .irq_req        (irq_req),
   .irq_ack        (irq_ack),
   .irq_vec        (irq_vec),
   .svc_hi         (svc_hi),
   .svc_lo         (svc_lo)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  ext_n, ext_edge, tmr_ovf;
   logic        ser_irq, glb_en, instr_boundary, reti;
   logic [4:0]  irq_en, irq_prio;
   logic        irq_req, irq_ack;
   logic [15:0] irq_vec;

   int checks   = 0;
   int failures = 0;

   always #2 clk = ~clk;

   irq_vector_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
      .tmr_ovf(tmr_ovf), .ser_irq(ser_irq), .glb_en(glb_en),
      .irq_en(irq_en), .irq_prio(irq_prio), .instr_boundary(instr_boundary),
      .reti(reti), .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec)
   );

   // {active[4:0], en[4:0], glb, prio[4:0], exp_req, exp_idx[2:0]}
   // active: bits 0/2 pull the external line low (level mode), bits 1/3 pulse a timer, bit 4 raises serial
   localparam int NV = 9;
   localparam logic [19:0] TBL [NV] = '{
      {5'b11111, 5'b11111, 1'b1, 5'b00000, 1'b1, 3'd0},
      {5'b11111, 5'b11111, 1'b1, 5'b10000, 1'b1, 3'd4},
      {5'b11111, 5'b11111, 1'b1, 5'b01010, 1'b1, 3'd1},
      {5'b11100, 5'b11111, 1'b1, 5'b00000, 1'b1, 3'd2},
      {5'b11111, 5'b11111, 1'b0, 5'b00000, 1'b0, 3'd0},
      {5'b00101, 5'b11010, 1'b1, 5'b00000, 1'b0, 3'd0},
      {5'b11000, 5'b11111, 1'b1, 5'b10000, 1'b1, 3'd4},
      {5'b00110, 5'b00110, 1'b1, 5'b00100, 1'b1, 3'd2},
      {5'b01000, 5'b01000, 1'b1, 5'b00000, 1'b1, 3'd3}
   };

   function automatic logic [15:0] vec_of(input int i);
      return 16'(3 + 8 * i);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ext_n = 2'b11; ext_edge = 2'b00; tmr_ovf = 2'b00; ser_irq = 1'b0;
      glb_en = 1'b1; irq_en = 5'b11111; irq_prio = 5'b00000;
      instr_boundary = 1'b0; reti = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle_inputs();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic grant(input logic [15:0] exp_vec, input string tag);
      instr_boundary = 1'b1;
      @(negedge clk);
      instr_boundary = 1'b0;
      chk(irq_ack === 1'b1, {tag, " ack"}, 32'(irq_ack), 32'd1);
      chk(irq_vec === exp_vec, {tag, " vector"}, 32'(irq_vec), 32'(exp_vec));
   endtask

   task automatic do_reti();
      reti = 1'b1;
      @(negedge clk);
      reti = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      do_reset();

      // R1 reset state
      chk(irq_req === 1'b0, "R1 req", 32'(irq_req), 0);
      chk(irq_ack === 1'b0, "R1 ack", 32'(irq_ack), 0);
      chk(irq_vec === 16'h0, "R1 vec", 32'(irq_vec), 0);

      // Table walk: R5 masking, R6 priority, R7 vectors
      for (int n = 0; n < NV; n++) begin
         automatic logic [19:0] e = TBL[n];
         automatic logic [4:0]  act = e[19:15];
         automatic logic [2:0]  xi  = e[2:0];
         do_reset();
         irq_en   = e[14:10];
         glb_en   = e[9];
         irq_prio = e[8:4];
         ext_n    = ~{act[2], act[0]};
         ser_irq  = act[4];
         tmr_ovf  = {act[3], act[1]};
         @(negedge clk);
         tmr_ovf  = 2'b00;
         chk(irq_req === e[3], $sformatf("R5/R6 row %0d req", n), 32'(irq_req), 32'(e[3]));
         if (e[3]) grant(vec_of(int'(xi)), $sformatf("R6/R7 row %0d", n));
      end

      // R2 level mode follows and withdraws
      do_reset();
      ext_n[0] = 1'b0;
      @(negedge clk);
      chk(irq_req === 1'b1, "R2 level asserted", 32'(irq_req), 1);
      ext_n[0] = 1'b1;
      @(negedge clk);
      chk(irq_req === 1'b0, "R2 level released", 32'(irq_req), 0);

      // R3 edge mode latches, cleared on grant
      do_reset();
      ext_edge = 2'b10;
      ext_n[1] = 1'b0;
      @(negedge clk);
      ext_n[1] = 1'b1;
      @(negedge clk);
      chk(irq_req === 1'b1, "R3 edge latched", 32'(irq_req), 1);
      @(negedge clk);
      chk(irq_req === 1'b1, "R3 edge held", 32'(irq_req), 1);
      grant(16'h0013, "R3 edge");
      do_reti();
      chk(irq_req === 1'b0, "R3 flag cleared by grant", 32'(irq_req), 0);

      // R4 serial persists, timer clears
      do_reset();
      ser_irq = 1'b1;
      @(negedge clk);
      grant(16'h0023, "R4 serial");
      do_reti();
      chk(irq_req === 1'b1, "R4 serial not cleared", 32'(irq_req), 1);
      ser_irq = 1'b0;
      @(negedge clk);
      chk(irq_req === 1'b0, "R4 serial follows input", 32'(irq_req), 0);
      tmr_ovf = 2'b01;
      @(negedge clk);
      tmr_ovf = 2'b00;
      grant(16'h000B, "R4 timer0");
      do_reti();
      chk(irq_req === 1'b0, "R4 timer flag cleared", 32'(irq_req), 0);

      // R9 / R10 nesting
      do_reset();
      ext_n[0] = 1'b0;
      @(negedge clk);
      grant(16'h0003, "R9 low grant");
      chk(irq_req === 1'b0, "R9 same level blocked", 32'(irq_req), 0);
      irq_prio = 5'b01000;
      tmr_ovf  = 2'b10;
      @(negedge clk);
      tmr_ovf  = 2'b00;
      chk(irq_req === 1'b1, "R9 high preempts low", 32'(irq_req), 1);
      grant(16'h001B, "R9 high grant");
      irq_prio = 5'b01010;
      tmr_ovf  = 2'b01;
      @(negedge clk);
      tmr_ovf  = 2'b00;
      chk(irq_req === 1'b0, "R9 high blocks high", 32'(irq_req), 0);
      do_reti();
      chk(irq_req === 1'b1, "R10 reti ends high level", 32'(irq_req), 1);
      grant(16'h000B, "R10 second high grant");
      do_reti();
      chk(irq_req === 1'b0, "R10 low still in service", 32'(irq_req), 0);
      do_reti();
      chk(irq_req === 1'b1, "R10 reti ends low level", 32'(irq_req), 1);

      // R8 no grant without boundary, vector held
      repeat (3) @(negedge clk);
      chk(irq_ack === 1'b0, "R8 no boundary no ack", 32'(irq_ack), 0);
      chk(irq_vec === 16'h000B, "R8 vector held", 32'(irq_vec), 32'h000B);
      // R10 reti suppresses grant in the same cycle
      instr_boundary = 1'b1;
      reti = 1'b1;
      @(negedge clk);
      instr_boundary = 1'b0;
      reti = 1'b0;
      chk(irq_ack === 1'b0, "R10 grant suppressed by reti", 32'(irq_ack), 0);
      grant(16'h0003, "R8 later grant");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule